// File: doc/BRIEF.md
# Calendar Counter with Alarm

This block keeps the time of day and the calendar date, advancing by one second on each accepted pulse of a 1 Hz enable. The count is held internally as plain binary (seconds, minutes, hours 0–23, weekday 1–7, day of month, month 1–12, two-digit year 0–99). It is presented on byte-wide output registers in either BCD or binary, with hours shown in 24-hour or 12-hour form, as chosen by two format inputs. A leap-year calendar is built in. The two-digit year is offset by the `BASE_YEAR` parameter to give the full year that the leap rule uses.

Each accepted second runs a two-phase update. On the first edge the count steps and the busy flag rises. `UPD_DELAY` clock cycles later the outputs are refreshed, the busy flag drops and the update-done pulse is given. The alarm bytes are compared against the new count in the same cycle, and the interrupt-cause pulses are derived from that comparison. A hold input freezes the visible outputs and the busy flag while the counter keeps running, so that software can write a consistent time. A load strobe writes all seven fields at once, each one decoded in the format currently selected.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00. The busy flag and all three pulses are low.
- R2: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day. The weekday counts 1 to 7 and returns to 1.
- R3: Day of month wraps to 1 after 31 for months 1, 3, 5, 7, 8, 10 and 12. It wraps after 30 for months 4, 6, 9 and 11. For month 2 it wraps after 28, or after 29 when the full year (`BASE_YEAR` + year) is divisible by 4 and either not by 100 or by 400. A month value outside 1–12 is treated as a 31-day month.
- R4: The month wraps from 12 to 1 and then increments the year. The year wraps from 99 to 0.
- R5: When `fmt_bin` is 0, every field is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. When `fmt_bin` is 1, every field is plain binary. Loads are decoded in the same format.
- R6: When `fmt_24h` is 0, the hours byte holds hour mod 12 in bits 6:0, with bit 7 set for hours 12–23. On load, bits 6:0 are decoded and 12 is added when bit 7 is set. When `fmt_24h` is 1, the hours byte holds 0–23.
- R7: A tick is accepted only when `osc_sel` equals 3'b010. With any other value, the tick causes no count, no busy flag and no pulse.
- R8: `upd_busy` is high from the edge that accepts a tick until the edge `UPD_DELAY` cycles later. At that later edge the outputs show the new count and `upd_done` pulses for one cycle. Before that edge the outputs keep the old value.
- R9: While `set_hold` is high, `upd_busy` stays low, updates do not refresh the outputs, and the update does not raise `irq_hit`. The counter still advances, and the advance becomes visible after release.
- R10: With `alarm_en` high, `alarm_hit` and `irq_hit` pulse with `upd_done` when each of the seconds, minutes and hours alarm bytes either has bits 7:6 equal to 2'b11 or decodes to the current value. The hours alarm byte is compared with the 0–23 hour. With `alarm_en` low there is no `alarm_hit`.
- R11: `upd_done` pulses on every completed update. `irq_hit` also pulses for an update only when `upd_irq_en` is high.
- R12: A change of `fmt_bin` or `fmt_24h` while `set_hold` is low re-encodes the outputs at the next edge. While `set_hold` is high it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| osc_sel | input | 3 | Oscillator control; counting only at 3'b010 |
| fmt_bin | input | 1 | 1 selects binary, 0 selects BCD |
| fmt_24h | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM bit |
| set_hold | input | 1 | Freezes outputs and busy flag while high |
| upd_irq_en | input | 1 | Enables interrupt on update completion |
| alarm_en | input | 1 | Enables the alarm comparison |
| load_en | input | 1 | Writes the ld_* fields into the count |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_wday | input | 8 | Weekday to load (1–7) |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load (1–12) |
| ld_year | input | 8 | Two-digit year to load |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| out_sec | output | 8 | Seconds field |
| out_min | output | 8 | Minutes field |
| out_hour | output | 8 | Hours field |
| out_wday | output | 8 | Weekday field |
| out_mday | output | 8 | Day-of-month field |
| out_mon | output | 8 | Month field |
| out_year | output | 8 | Year field |
| upd_busy | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse at update completion |
| alarm_hit | output | 1 | One-cycle pulse when the alarm matches |
| irq_hit | output | 1 | One-cycle pulse when an interrupt cause is raised |

## Verification
The hardest states to reach from the ports are the rare calendar corners: the end of each month length, the leap February, the century year that is not leap, and the year wrap. Counting there one second at a time would take months of simulated time. The stimulus instead loads the last second of every month for several chosen years and gives one tick. A second instance with a base year of 1900 makes the year-00 February non-leap. The hold window is exercised by ticking while it is asserted and then checking that the frozen output jumps by the accumulated seconds after release.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int FW = 8;

  typedef struct packed {
    logic [FW-1:0] sec;
    logic [FW-1:0] min;
    logic [FW-1:0] hour;
    logic [FW-1:0] wday;
    logic [FW-1:0] mday;
    logic [FW-1:0] mon;
    logic [FW-1:0] year;
  } cal_t;

  localparam logic [FW-1:0] SEC_WRAP  = 8'd60;
  localparam logic [FW-1:0] MIN_WRAP  = 8'd60;
  localparam logic [FW-1:0] HOUR_WRAP = 8'd24;
  localparam logic [FW-1:0] WDAY_MAX  = 8'd7;
  localparam logic [FW-1:0] MON_MAX   = 8'd12;
  localparam logic [FW-1:0] YEAR_MAX  = 8'd99;
  localparam logic [2:0]    OSC_RUN   = 3'b010;

  localparam cal_t CAL_RST = '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
                               mday: 8'd1, mon: 8'd1, year: 8'd0};

  function automatic logic [FW-1:0] enc8(input logic [FW-1:0] v, input logic bin);
    logic [FW-1:0] t, u;
    t = v / 8'd10;
    u = v % 8'd10;
    return bin ? v : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [FW-1:0] dec8(input logic [FW-1:0] x, input logic bin);
    logic [FW-1:0] hi, lo;
    hi = {4'd0, x[7:4]};
    lo = {4'd0, x[3:0]};
    return bin ? x : (hi * 8'd10 + lo);
  endfunction

  function automatic logic [FW-1:0] enc_hour(input logic [FW-1:0] h, input logic bin,
                                             input logic h24);
    logic [FW-1:0] r;
    if (h24) r = enc8(h, bin);
    else begin
      r = enc8(h % 8'd12, bin);
      if (h >= 8'd12) r[7] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] dec_hour(input logic [FW-1:0] x, input logic bin,
                                             input logic h24);
    logic [FW-1:0] v;
    v = dec8({1'b0, x[6:0]}, bin);
    if (!h24 && x[7]) v = v + 8'd12;
    return v;
  endfunction

  function automatic cal_t encode_all(input cal_t c, input logic bin, input logic h24);
    cal_t r;
    r.sec  = enc8(c.sec, bin);
    r.min  = enc8(c.min, bin);
    r.hour = enc_hour(c.hour, bin, h24);
    r.wday = enc8(c.wday, bin);
    r.mday = enc8(c.mday, bin);
    r.mon  = enc8(c.mon, bin);
    r.year = enc8(c.year, bin);
    return r;
  endfunction

  function automatic cal_t decode_all(input cal_t c, input logic bin, input logic h24);
    cal_t r;
    r.sec  = dec8(c.sec, bin);
    r.min  = dec8(c.min, bin);
    r.hour = dec_hour(c.hour, bin, h24);
    r.wday = dec8(c.wday, bin);
    r.mday = dec8(c.mday, bin);
    r.mon  = dec8(c.mon, bin);
    r.year = dec8(c.year, bin);
    return r;
  endfunction

  function automatic logic [FW-1:0] month_len(input logic [FW-1:0] mon, input logic leap);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      8'd2:                    return leap ? 8'd29 : 8'd28;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_count.sv
`timescale 1ns/1ps
module rtc_cal_count
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic load,
  input  cal_t ld,
  output cal_t tm
);
  localparam logic [15:0] BASE = 16'(BASE_YEAR);

  cal_t          nx;
  logic [15:0]   full;
  logic          leap;
  logic [FW-1:0] mlen;

  always_comb begin
    full = BASE + {8'd0, tm.year};
    leap = (full % 16'd4 == 16'd0) &&
           ((full % 16'd100 != 16'd0) || (full % 16'd400 == 16'd0));
    mlen = month_len(tm.mon, leap);
    nx   = tm;
    if (tm.sec + 8'd1 < SEC_WRAP) nx.sec = tm.sec + 8'd1;
    else begin
      nx.sec = 8'd0;
      if (tm.min + 8'd1 < MIN_WRAP) nx.min = tm.min + 8'd1;
      else begin
        nx.min = 8'd0;
        if (tm.hour + 8'd1 < HOUR_WRAP) nx.hour = tm.hour + 8'd1;
        else begin
          nx.hour = 8'd0;
          nx.wday = (tm.wday >= WDAY_MAX) ? 8'd1 : tm.wday + 8'd1;
          if (tm.mday + 8'd1 == 8'd0) nx.mday = 8'd1;
          else if (tm.mday + 8'd1 <= mlen) nx.mday = tm.mday + 8'd1;
          else begin
            nx.mday = 8'd1;
            if (tm.mon >= MON_MAX) begin
              nx.mon  = 8'd1;
              nx.year = (tm.year >= YEAR_MAX) ? 8'd0 : tm.year + 8'd1;
            end else nx.mon = tm.mon + 8'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       tm <= CAL_RST;
    else if (load) tm <= ld;
    else if (step) tm <= nx;
  end
endmodule

// File: rtl/rtc_cal_seq.sv
`timescale 1ns/1ps
module rtc_cal_seq #(
  parameter int UPD_DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic osc_ok,
  input  logic set_hold,
  output logic start,
  output logic fin,
  output logic uip
);
  localparam int CW = $clog2(UPD_DELAY + 1);

  logic          pending;
  logic [CW-1:0] cnt;

  assign start = tick && osc_ok && !pending;
  assign fin   = pending && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt     <= '0;
      uip     <= 1'b0;
    end else begin
      if (start) begin
        pending <= 1'b1;
        cnt     <= CW'(UPD_DELAY);
      end else if (fin) pending <= 1'b0;
      else if (pending) cnt <= cnt - CW'(1);

      if (set_hold)   uip <= 1'b0;
      else if (start) uip <= 1'b1;
      else if (fin)   uip <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_cal_out.sv
`timescale 1ns/1ps
module rtc_cal_out
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic copy,
  input  cal_t tm,
  input  logic bin,
  input  logic h24,
  output cal_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= CAL_RST;
    else if (copy) q <= encode_all(tm, bin, h24);
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000,
  parameter int UPD_DELAY = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_1hz,
  input  logic [2:0]    osc_sel,
  input  logic          fmt_bin,
  input  logic          fmt_24h,
  input  logic          set_hold,
  input  logic          upd_irq_en,
  input  logic          alarm_en,
  input  logic          load_en,
  input  logic [7:0]    ld_sec,
  input  logic [7:0]    ld_min,
  input  logic [7:0]    ld_hour,
  input  logic [7:0]    ld_wday,
  input  logic [7:0]    ld_mday,
  input  logic [7:0]    ld_mon,
  input  logic [7:0]    ld_year,
  input  logic [7:0]    alm_sec,
  input  logic [7:0]    alm_min,
  input  logic [7:0]    alm_hour,
  output logic [7:0]    out_sec,
  output logic [7:0]    out_min,
  output logic [7:0]    out_hour,
  output logic [7:0]    out_wday,
  output logic [7:0]    out_mday,
  output logic [7:0]    out_mon,
  output logic [7:0]    out_year,
  output logic          upd_busy,
  output logic          upd_done,
  output logic          alarm_hit,
  output logic          irq_hit
);
  cal_t       ld_raw, ld_dec, tm, out_q;
  logic       start, fin, copy, fmt_chg, load_q, match;
  logic [1:0] fmt_q;

  always_comb begin
    ld_raw.sec  = ld_sec;
    ld_raw.min  = ld_min;
    ld_raw.hour = ld_hour;
    ld_raw.wday = ld_wday;
    ld_raw.mday = ld_mday;
    ld_raw.mon  = ld_mon;
    ld_raw.year = ld_year;
    ld_dec      = decode_all(ld_raw, fmt_bin, fmt_24h);
  end

  rtc_cal_seq #(.UPD_DELAY(UPD_DELAY)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_1hz), .osc_ok(osc_sel == OSC_RUN),
    .set_hold(set_hold), .start(start), .fin(fin), .uip(upd_busy)
  );

  rtc_cal_count #(.BASE_YEAR(BASE_YEAR)) u_count (
    .clk(clk), .rst(rst), .step(start), .load(load_en), .ld(ld_dec), .tm(tm)
  );

  assign fmt_chg = (fmt_q != {fmt_bin, fmt_24h});
  assign copy    = ((fin || fmt_chg) && !set_hold) || load_q;

  rtc_cal_out u_out (
    .clk(clk), .rst(rst), .copy(copy), .tm(tm), .bin(fmt_bin), .h24(fmt_24h), .q(out_q)
  );

  assign match = ((alm_sec[7:6]  == 2'b11) || (dec8(alm_sec, fmt_bin)  == tm.sec)) &&
                 ((alm_min[7:6]  == 2'b11) || (dec8(alm_min, fmt_bin)  == tm.min)) &&
                 ((alm_hour[7:6] == 2'b11) || (dec8(alm_hour, fmt_bin) == tm.hour));

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q     <= 2'b00;
      load_q    <= 1'b0;
      upd_done  <= 1'b0;
      alarm_hit <= 1'b0;
      irq_hit   <= 1'b0;
    end else begin
      fmt_q     <= {fmt_bin, fmt_24h};
      load_q    <= load_en;
      upd_done  <= fin;
      alarm_hit <= fin && alarm_en && match;
      irq_hit   <= fin && ((upd_irq_en && !set_hold) || (alarm_en && match));
    end
  end

  assign out_sec  = out_q.sec;
  assign out_min  = out_q.min;
  assign out_hour = out_q.hour;
  assign out_wday = out_q.wday;
  assign out_mday = out_q.mday;
  assign out_mon  = out_q.mon;
  assign out_year = out_q.year;
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic [2:0] osc_sel,
  input logic       set_hold,
  input logic       alarm_en,
  input logic       upd_busy,
  input logic       upd_done,
  input logic       alarm_hit,
  input logic       irq_hit
);
  p_idle_without_run_r7: assert property (@(posedge clk) disable iff (rst)
    (!upd_busy && !(tick_1hz && osc_sel == 3'b010)) |=> !upd_busy);

  p_busy_low_in_hold_r9: assert property (@(posedge clk) disable iff (rst)
    set_hold |=> !upd_busy);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> !upd_busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

  p_alarm_gated_r10: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> $past(alarm_en));

  p_alarm_raises_irq_r10: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> (irq_hit && upd_done));

  p_irq_at_update_r11: assert property (@(posedge clk) disable iff (rst)
    irq_hit |-> upd_done);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .osc_sel(osc_sel), .set_hold(set_hold),
  .alarm_en(alarm_en), .upd_busy(upd_busy), .upd_done(upd_done),
  .alarm_hit(alarm_hit), .irq_hit(irq_hit)
);

// File: tb/test_rtc_calendar.sv
`timescale 1ns/1ps
module test_rtc_calendar;
  localparam int DLY = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_1hz = 0, fmt_bin = 0, fmt_24h = 1, set_hold = 0;
  logic upd_irq_en = 0, alarm_en = 0, load_en = 0;
  logic [2:0] osc_sel = 3'b010;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_mday = 0, ld_mon = 0, ld_year = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0;
  logic [7:0] out_sec, out_min, out_hour, out_wday, out_mday, out_mon, out_year;
  logic upd_busy, upd_done, alarm_hit, irq_hit;
  logic [7:0] c_sec, c_min, c_hour, c_wday, c_mday, c_mon, c_year;
  logic c_busy, c_done, c_alarm, c_irq;

  int total = 0, fails = 0;
  logic seen_busy, seen_done, seen_alarm, seen_irq;
  logic [7:0] pre_sec;

  always #5 clk = ~clk;

  rtc_calendar #(.BASE_YEAR(2000), .UPD_DELAY(DLY)) i_rtc_calendar (.*);

  rtc_calendar #(.BASE_YEAR(1900), .UPD_DELAY(DLY)) i_rtc_calendar_c19 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .osc_sel(osc_sel), .fmt_bin(fmt_bin),
    .fmt_24h(fmt_24h), .set_hold(set_hold), .upd_irq_en(upd_irq_en), .alarm_en(alarm_en),
    .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
    .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year), .alm_sec(alm_sec),
    .alm_min(alm_min), .alm_hour(alm_hour), .out_sec(c_sec), .out_min(c_min),
    .out_hour(c_hour), .out_wday(c_wday), .out_mday(c_mday), .out_mon(c_mon),
    .out_year(c_year), .upd_busy(c_busy), .upd_done(c_done), .alarm_hit(c_alarm),
    .irq_hit(c_irq)
  );

  function automatic logic [7:0] tenc(int v, bit bin);
    return bin ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] thour(int h, bit bin, bit h24);
    if (h24) return tenc(h, bin);
    return tenc(h % 12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int tdim(int m, int y);
    bit lp;
    lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_time(int s, int mi, int h, int wd, int md, int mo, int y);
    ld_sec = tenc(s, fmt_bin);  ld_min = tenc(mi, fmt_bin); ld_hour = thour(h, fmt_bin, fmt_24h);
    ld_wday = tenc(wd, fmt_bin); ld_mday = tenc(md, fmt_bin);
    ld_mon = tenc(mo, fmt_bin); ld_year = tenc(y, fmt_bin);
    load_en = 1; step(); load_en = 0; step(); step();
  endtask

  task automatic one_second();
    tick_1hz = 1; step(); tick_1hz = 0;
    seen_busy = upd_busy;
    repeat (DLY - 1) step();
    pre_sec = out_sec;
    step();
    seen_done = upd_done; seen_alarm = alarm_hit; seen_irq = irq_hit;
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int ys[4] = '{0, 1, 4, 99};
    repeat (3) step();
    rst = 0; step();

    // R1 reset state
    check("R1 sec", out_sec, 8'h00);  check("R1 min", out_min, 8'h00);
    check("R1 hour", out_hour, 8'h00); check("R1 wday", out_wday, 8'h01);
    check("R1 mday", out_mday, 8'h01); check("R1 mon", out_mon, 8'h01);
    check("R1 year", out_year, 8'h00);
    check("R1 flags", {upd_busy, upd_done, alarm_hit, irq_hit}, 4'b0000);

    // R5 R6 R2: hour carry across all format combinations
    for (int f = 0; f < 4; f++) begin
      fmt_bin = f[1]; fmt_24h = f[0]; step(); step();
      for (int h = 0; h < 24; h++) begin
        load_time(59, 59, h, 3, 15, 6, 10);
        check("R6 load echo hour", out_hour, thour(h, fmt_bin, fmt_24h));
        one_second();
        check("R5 R6 hour", out_hour, thour((h + 1) % 24, fmt_bin, fmt_24h));
        check("R2 sec min wrap", {out_min, out_sec}, 16'h0000);
        check("R5 mday", out_mday, tenc(h == 23 ? 16 : 15, fmt_bin));
      end
    end
    fmt_bin = 0; fmt_24h = 1; step(); step();

    // R3 R4 R2: last second of each month for several years
    foreach (ys[k]) begin
      for (int m = 1; m <= 12; m++) begin
        load_time(59, 59, 23, 7, tdim(m, 2000 + ys[k]), m, ys[k]);
        one_second();
        check("R3 mday wrap", out_mday, 8'h01);
        check("R4 mon", out_mon, tenc(m == 12 ? 1 : m + 1, 0));
        check("R4 year", out_year, tenc(m == 12 ? (ys[k] + 1) % 100 : ys[k], 0));
        check("R2 wday wrap", out_wday, 8'h01);
      end
    end

    // R3 century rule: 2000 leap, 1900 not
    load_time(59, 59, 23, 3, 28, 2, 0);
    one_second();
    check("R3 leap 2000 mday", {out_mday, out_mon}, 16'h2902);
    check("R3 non-leap 1900 mday", {c_mday, c_mon}, 16'h0103);
    // R3 out-of-range month is 31 days
    load_time(59, 59, 23, 3, 30, 13, 5);
    one_second();
    check("R3 month 13 day 31", out_mday, 8'h31);

    // R8 two-phase timing
    load_time(10, 20, 8, 2, 3, 4, 5);
    one_second();
    check("R8 busy after tick", seen_busy, 1'b1);
    check("R8 old value before delay", pre_sec, 8'h10);
    check("R8 new value at delay", out_sec, 8'h11);
    check("R8 done pulse", seen_done, 1'b1);
    check("R8 busy cleared", upd_busy, 1'b0);
    step();
    check("R8 done one cycle", upd_done, 1'b0);

    // R7 oscillator control
    osc_sel = 3'b000; one_second();
    check("R7 no busy", seen_busy, 1'b0);
    check("R7 no done", seen_done, 1'b0);
    check("R7 no count", out_sec, 8'h11);
    osc_sel = 3'b110; one_second();
    check("R7 no count alt", {seen_busy, seen_done, out_sec}, {2'b00, 8'h11});
    osc_sel = 3'b010;

    // R11 update interrupt
    upd_irq_en = 0; one_second();
    check("R11 done without irq", {seen_done, seen_irq}, 2'b10);
    upd_irq_en = 1; one_second();
    check("R11 irq enabled", {seen_done, seen_irq}, 2'b11);

    // R9 hold window
    set_hold = 1; step();
    one_second();
    check("R9 busy stays low", seen_busy, 1'b0);
    check("R9 outputs frozen", out_sec, 8'h13);
    check("R9 done but no irq", {seen_done, seen_irq}, 2'b10);
    one_second();
    set_hold = 0; upd_irq_en = 0; step();
    one_second();
    check("R9 count ran during hold", out_sec, 8'h16);

    // R10 alarm: time now 08:20:16, next second 17
    alm_sec = 8'h17; alm_min = 8'h20; alm_hour = 8'h08; alarm_en = 1;
    one_second();
    check("R10 exact match", {seen_alarm, seen_irq}, 2'b11);
    alm_sec = 8'hC5; one_second();
    check("R10 wildcard sec", {seen_alarm, seen_irq}, 2'b11);
    alm_min = 8'h21; one_second();
    check("R10 minute mismatch", {seen_alarm, seen_irq}, 2'b00);
    alm_min = 8'hFF; alm_hour = 8'hC0; alarm_en = 0; one_second();
    check("R10 disabled", {seen_alarm, seen_irq}, 2'b00);
    alarm_en = 1; one_second();
    check("R10 all wildcards", seen_alarm, 1'b1);
    alarm_en = 0;

    // R12 format change re-encodes; time 15:07:08
    fmt_bin = 0; fmt_24h = 1; step(); step();
    load_time(8, 7, 15, 1, 1, 1, 1);
    fmt_bin = 1; step();
    check("R12 binary after change", {out_hour, out_min, out_sec}, 24'h0F0708);
    fmt_24h = 0; step();
    check("R12 twelve-hour", out_hour, 8'h83);
    set_hold = 1; step(); fmt_bin = 0; step(); step();
    check("R12 no re-encode in hold", out_hour, 8'h83);
    set_hold = 0; step(); step();
    check("R12 after hold", out_hour, 8'h83);
    fmt_24h = 1; step();
    check("R12 bcd 24h", out_hour, 8'h15);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule